// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small 8-bit accumulator machine. It holds the accumulator and the flag byte in two registers. On each one-cycle strobe it applies one operation to the accumulator, an operand byte and the stored carry. The operations are add, add with carry, subtract, subtract with borrow, compare, AND, XOR, OR, increment, decrement and decimal adjust. The new accumulator and flag byte are written back on the same clock edge.

The flag byte follows a fixed layout that the rest of a processor decodes. Subtract-type operations mark themselves in bit 1. The half-carry after subtraction is stored in inverted form. A single mode input picks between two rules for the half-carry that AND leaves behind. Increment and decrement leave the carry alone, so multi-byte loops can keep a carry chain across them.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe, `acc_q` and `flags_q` both read 0x00.
- R2: `acc_q` and `flags_q` change only on a clock edge where `op_go` is 1. A strobe that carries an `op_sel` code from 11 to 15 leaves both unchanged.
- R3: `op_sel` codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 XOR, 7 OR, 8 increment, 9 decrement, 10 decimal adjust. Flag bits are sign 7, zero 6, half-carry 4, parity 2, subtract mark 1 and carry 0. Sign is bit 7 of the result and zero is set when the result byte is 0x00. Parity is 1 when the result has an even number of ones. Bits 5 and 3 are 0 for every operation except decimal adjust.
- R4: Add and add-with-carry write the low byte of A + B (+ stored carry for code 1). Carry is bit 8 of the 9-bit sum. Half-carry is bit 4 of A xor B xor result. Bit 1 is 0.
- R5: Subtract and subtract-with-borrow write A − B (− stored carry for code 3). Carry is the borrow out of bit 7. Half-carry is the inverse of bit 4 of A xor B xor result. Bit 1 is 1.
- R6: Compare sets the flags exactly as subtract would and leaves the accumulator unchanged.
- R7: AND writes A & B and clears carry. With `flag_mode` = 1 the half-carry is always set. With `flag_mode` = 0 it equals bit 3 of A | B.
- R8: XOR and OR write their result, take sign, zero and parity from it, and clear half-carry and carry.
- R9: Increment adds one to the accumulator. Half-carry is set when the old low nibble was 0xF. Carry keeps its old value and bit 1 is 0.
- R10: Decrement subtracts one from the accumulator. Half-carry is set when the old low nibble was not zero. Bit 1 is 1 and carry keeps its old value.
- R11: Decimal adjust adds 0x06 when the old low nibble exceeds 9 or the stored half-carry is 1. It also adds 0x60 when the old accumulator exceeds 0x99 or the stored carry is 1. The two additions are cumulative.
- R12: After decimal adjust, bit 1 keeps its old value. Carry is the old carry ORed with (old A > 0x99). Bits 5 and 3 copy the old accumulator. Half-carry is bit 4 of old A xor new A. Sign, zero and parity come from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_go | input | 1 | One-cycle strobe that commits the selected operation |
| op_sel | input | 4 | Operation code (see R3) |
| operand | input | 8 | Second operand byte |
| flag_mode | input | 1 | Half-carry rule for AND: 1 forces it, 0 uses bit 3 of A OR B |
| acc_q | output | 8 | Registered accumulator |
| flags_q | output | 8 | Registered flag byte |

## Verification
The hardest case to reach from the ports is decimal adjust with both stored half-carry and carry set, and with the old accumulator above 0x99. The accumulator cannot be loaded directly, and a load through XOR clears both carries. The stimulus therefore loads a chosen value with XOR and then runs an add or subtract that leaves the wanted carry state behind. For example, 0x88 + 0x88 leaves 0x10 with both carries set, and 0x00 − 0xD1 leaves 0x2F with carry set. The decimal adjust or increment/decrement under test follows directly after. A long pseudo-random stream of operations and modes then covers carry chains between consecutive operations.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW = 8;
    localparam int NW = DW / 2;

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDC   = 4'd1,
        OP_SUB    = 4'd2,
        OP_SUBB   = 4'd3,
        OP_CMP    = 4'd4,
        OP_AND    = 4'd5,
        OP_XOR    = 4'd6,
        OP_OR     = 4'd7,
        OP_INC    = 4'd8,
        OP_DEC    = 4'd9,
        OP_DECADJ = 4'd10
    } alu_op_e;

    // flag byte bit positions (decoded by neighbouring logic)
    localparam int FB_C  = 0;
    localparam int FB_N  = 1;
    localparam int FB_P  = 2;
    localparam int FB_X3 = 3;
    localparam int FB_H  = 4;
    localparam int FB_X5 = 5;
    localparam int FB_Z  = 6;
    localparam int FB_S  = 7;

    // sign, zero and even-parity bits of a result, all other bits zero
    function automatic byte_t szp_of(input byte_t r);
        byte_t f;
        f       = '0;
        f[FB_S] = r[DW-1];
        f[FB_Z] = (r == '0);
        f[FB_P] = ~^r;
        return f;
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
    import acc_alu_pkg::*;
(
    input  byte_t a_in,
    input  byte_t b_in,
    input  logic  c_in,
    input  logic  sub_en,
    input  logic  cin_en,
    output byte_t res_out,
    output byte_t flg_out
);

    logic [DW:0] sum;
    byte_t       hx;
    logic        cy;

    always_comb begin
        cy = c_in & cin_en;
        if (sub_en)
            sum = {1'b0, a_in} - {1'b0, b_in} - {{DW{1'b0}}, cy};
        else
            sum = {1'b0, a_in} + {1'b0, b_in} + {{DW{1'b0}}, cy};
        hx            = a_in ^ b_in ^ sum[DW-1:0];
        res_out       = sum[DW-1:0];
        flg_out       = szp_of(sum[DW-1:0]);
        // half-carry is stored inverted for subtraction
        flg_out[FB_H] = hx[NW] ^ sub_en;
        flg_out[FB_C] = sum[DW];
        flg_out[FB_N] = sub_en;
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  byte_t   a_in,
    input  byte_t   b_in,
    input  alu_op_e op,
    input  logic    h_forced,
    output byte_t   res_out,
    output byte_t   flg_out
);

    always_comb begin
        case (op)
            OP_AND:  res_out = a_in & b_in;
            OP_XOR:  res_out = a_in ^ b_in;
            default: res_out = a_in | b_in;
        endcase
        flg_out = szp_of(res_out);
        if (op == OP_AND)
            flg_out[FB_H] = h_forced | a_in[NW-1] | b_in[NW-1];
    end

endmodule

// File: rtl/acc_alu_step.sv
module acc_alu_step
    import acc_alu_pkg::*;
(
    input  byte_t a_in,
    input  logic  dec_en,
    input  logic  c_in,
    output byte_t res_out,
    output byte_t flg_out
);

    localparam logic [NW-1:0] NIB_FULL = '1;

    always_comb begin
        res_out = dec_en ? (a_in - byte_t'(1)) : (a_in + byte_t'(1));
        flg_out = szp_of(res_out);
        flg_out[FB_H] = dec_en ? (a_in[NW-1:0] != '0)
                               : (a_in[NW-1:0] == NIB_FULL);
        flg_out[FB_N] = dec_en;
        flg_out[FB_C] = c_in;
    end

endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
    import acc_alu_pkg::*;
(
    input  byte_t      a_in,
    input  logic       h_in,
    input  logic       c_in,
    input  logic       n_in,
    output byte_t      res_out,
    output byte_t      flg_out
);

    localparam byte_t LO_FIX = 8'h06;
    localparam byte_t HI_FIX = 8'h60;
    localparam byte_t HI_LIM = 8'h99;
    localparam logic [NW-1:0] LO_LIM = 4'd9;

    logic hi_over;

    always_comb begin
        hi_over = (a_in > HI_LIM);
        res_out = a_in;
        if ((a_in[NW-1:0] > LO_LIM) || h_in)
            res_out = res_out + LO_FIX;
        if (hi_over || c_in)
            res_out = res_out + HI_FIX;
        flg_out        = szp_of(res_out);
        flg_out[FB_H]  = a_in[NW] ^ res_out[NW];
        flg_out[FB_X5] = a_in[FB_X5];
        flg_out[FB_X3] = a_in[FB_X3];
        flg_out[FB_N]  = n_in;
        flg_out[FB_C]  = c_in | hi_over;
    end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_go,
    input  logic [3:0]  op_sel,
    input  logic [7:0]  operand,
    input  logic        flag_mode,
    output logic [7:0]  acc_q,
    output logic [7:0]  flags_q
);

    alu_op_e op_e;
    byte_t   acc_nx, flg_nx;
    byte_t   as_res, as_flg, lg_res, lg_flg, st_res, st_flg, da_res, da_flg;
    logic    is_sub, use_cin;

    assign op_e    = alu_op_e'(op_sel);
    assign is_sub  = (op_e == OP_SUB) || (op_e == OP_SUBB) || (op_e == OP_CMP);
    assign use_cin = (op_e == OP_ADDC) || (op_e == OP_SUBB);

    acc_alu_addsub u_addsub (
        .a_in    (acc_q),
        .b_in    (operand),
        .c_in    (flags_q[FB_C]),
        .sub_en  (is_sub),
        .cin_en  (use_cin),
        .res_out (as_res),
        .flg_out (as_flg)
    );

    acc_alu_logic u_logic (
        .a_in     (acc_q),
        .b_in     (operand),
        .op       (op_e),
        .h_forced (flag_mode),
        .res_out  (lg_res),
        .flg_out  (lg_flg)
    );

    acc_alu_step u_step (
        .a_in    (acc_q),
        .dec_en  (op_e == OP_DEC),
        .c_in    (flags_q[FB_C]),
        .res_out (st_res),
        .flg_out (st_flg)
    );

    acc_alu_decadj u_decadj (
        .a_in    (acc_q),
        .h_in    (flags_q[FB_H]),
        .c_in    (flags_q[FB_C]),
        .n_in    (flags_q[FB_N]),
        .res_out (da_res),
        .flg_out (da_flg)
    );

    // next-value selection
    always_comb begin
        acc_nx = acc_q;
        flg_nx = flags_q;
        if (op_go) begin
            unique case (op_e)
                OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
                    acc_nx = as_res;
                    flg_nx = as_flg;
                end
                OP_CMP: flg_nx = as_flg;
                OP_AND, OP_XOR, OP_OR: begin
                    acc_nx = lg_res;
                    flg_nx = lg_flg;
                end
                OP_INC, OP_DEC: begin
                    acc_nx = st_res;
                    flg_nx = st_flg;
                end
                OP_DECADJ: begin
                    acc_nx = da_res;
                    flg_nx = da_flg;
                end
                default: ;
            endcase
        end
    end

    // register state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else begin
            acc_q   <= acc_nx;
            flags_q <= flg_nx;
        end
    end

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_go |=> ($stable(acc_q) && $stable(flags_q))); // R2

    AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_sel <= 4'd9) |=> (!flags_q[FB_X5] && !flags_q[FB_X3])); // R3

    AST_SUB_MARK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && (op_sel == 4'd2 || op_sel == 4'd3)) |=> flags_q[FB_N]); // R5

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_sel == 4'd4) |=> (acc_q == $past(acc_q))); // R6

    AST_AND_FORCED_H: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_sel == 4'd5 && flag_mode) |=> (flags_q[FB_H] && !flags_q[FB_C])); // R7

    AST_XOR_OR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && (op_sel == 4'd6 || op_sel == 4'd7)) |=> (!flags_q[FB_H] && !flags_q[FB_C])); // R8

    AST_INC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_sel == 4'd8) |=> (flags_q[FB_C] == $past(flags_q[FB_C]))); // R9

    AST_DEC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_sel == 4'd9) |=> (flags_q[FB_C] == $past(flags_q[FB_C]) && flags_q[FB_N])); // R10

    AST_DECADJ_KEEPS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_sel == 4'd10) |=> (flags_q[FB_N] == $past(flags_q[FB_N]))); // R12

endmodule

// File: tb/acc_alu_core_tb.sv
`timescale 1ns/1ps
module acc_alu_core_tb;

    localparam int C_ADD = 0, C_ADDC = 1, C_SUB = 2, C_SUBB = 3, C_CMP = 4,
                   C_AND = 5, C_XOR = 6, C_OR = 7, C_INC = 8, C_DEC = 9, C_DAJ = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_go = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] operand = '0;
    logic       flag_mode = 1'b0;
    logic [7:0] acc_q, flags_q;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 0;
    logic        drv_active = 1'b0;
    logic        cmp_due = 1'b0;
    logic [7:0]  mdl_a = '0;
    logic [7:0]  mdl_f = '0;

    acc_alu_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_go     (op_go),
        .op_sel    (op_sel),
        .operand   (operand),
        .flag_mode (flag_mode),
        .acc_q     (acc_q),
        .flags_q   (flags_q)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] szp(input logic [7:0] r);
        logic [7:0] f;
        f = 8'h00;
        f[7] = r[7];
        f[6] = (r == 8'h00);
        f[2] = ($countones(r) % 2) == 0;
        return f;
    endfunction

    // expected {acc, flags} derived from the requirement text
    function automatic logic [15:0] model(input int op, input logic [7:0] b,
                                          input logic m, input logic [7:0] a,
                                          input logic [7:0] f);
        int         q;
        logic [7:0] r, nf, t;
        r = a; nf = f;
        case (op)
            C_ADD, C_ADDC: begin
                q  = int'(a) + int'(b) + ((op == C_ADDC) ? int'(f[0]) : 0);
                r  = q[7:0]; t = a ^ b ^ r;
                nf = szp(r); nf[4] = t[4]; nf[0] = q[8];
            end
            C_SUB, C_SUBB, C_CMP: begin
                q  = int'(a) - int'(b) - ((op == C_SUBB) ? int'(f[0]) : 0);
                r  = q[7:0]; t = a ^ b ^ r;
                nf = szp(r); nf[4] = ~t[4]; nf[0] = q[8]; nf[1] = 1'b1;
                if (op == C_CMP) r = a;
            end
            C_AND: begin
                r = a & b; nf = szp(r);
                nf[4] = m ? 1'b1 : (a[3] | b[3]);
            end
            C_XOR: begin r = a ^ b; nf = szp(r); end
            C_OR:  begin r = a | b; nf = szp(r); end
            C_INC: begin
                r = a + 8'd1; nf = szp(r);
                nf[4] = (a[3:0] == 4'hF); nf[0] = f[0];
            end
            C_DEC: begin
                r = a - 8'd1; nf = szp(r);
                nf[4] = (a[3:0] != 4'h0); nf[1] = 1'b1; nf[0] = f[0];
            end
            C_DAJ: begin
                r = a;
                if (a[3:0] > 4'd9 || f[4]) r = r + 8'h06;
                if (a > 8'h99 || f[0])     r = r + 8'h60;
                t  = a ^ r;
                nf = szp(r);
                nf[1] = f[1]; nf[0] = f[0] | (a > 8'h99);
                nf[5] = a[5]; nf[3] = a[3]; nf[4] = t[4];
            end
            default: ;
        endcase
        return {r, nf};
    endfunction

    function automatic string req_of(input int op);
        case (op)
            C_ADD, C_ADDC:  return "R4";
            C_SUB, C_SUBB:  return "R5";
            C_CMP:          return "R6";
            C_AND:          return "R7";
            C_XOR, C_OR:    return "R8";
            C_INC:          return "R9";
            C_DEC:          return "R10";
            C_DAJ:          return "R11";
            default:        return "R2";
        endcase
    endfunction

    task automatic drive(input int op, input logic [7:0] b, input logic m,
                         input logic go, input string tag);
        logic [15:0] e;
        e = go ? model(op, b, m, mdl_a, mdl_f) : {mdl_a, mdl_f};
        mdl_a = e[15:8];
        mdl_f = e[7:0];
        exp_q.push_back(e);
        tag_q.push_back(tag);
        op_go = go; op_sel = op[3:0]; operand = b; flag_mode = m;
        drv_active = 1'b1;
        @(negedge clk);
        op_go = 1'b0;
        drv_active = 1'b0;
    endtask

    task automatic load_a(input logic [7:0] v);
        drive(C_XOR, mdl_a ^ v, 1'b0, 1'b1, "R8");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: compare against the scoreboard one edge after each driven item
    always @(posedge clk) cmp_due <= drv_active;

    always @(negedge clk) begin
        if (cmp_due) begin
            logic [15:0] e;
            string       t;
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 scoreboard empty: actual acc=%h flags=%h expected an item", acc_q, flags_q);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({acc_q, flags_q} !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual acc=%h flags=%h expected acc=%h flags=%h",
                             t, acc_q, flags_q, e[15:8], e[7:0]);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual run still active expected completion");
            summary();
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (acc_q !== 8'h00 || flags_q !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 in reset: actual acc=%h flags=%h expected 00 00", acc_q, flags_q);
        end
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        n_cmp++;
        if (acc_q !== 8'h00 || flags_q !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 after release: actual acc=%h flags=%h expected 00 00", acc_q, flags_q);
        end

        // add family: carry out, zero result, carry-in use
        load_a(8'h3A);
        drive(C_ADD,  8'hC6, 1'b0, 1'b1, "R4");
        drive(C_ADDC, 8'h10, 1'b0, 1'b1, "R4");
        // subtract family with borrow chain
        drive(C_SUB,  8'h20, 1'b0, 1'b1, "R5");
        drive(C_SUBB, 8'h01, 1'b0, 1'b1, "R5");
        drive(C_CMP,  8'h05, 1'b0, 1'b1, "R6");
        load_a(8'h42);
        drive(C_CMP,  8'h42, 1'b0, 1'b1, "R6");
        // AND half-carry rules
        load_a(8'hF0);
        drive(C_AND,  8'h0F, 1'b0, 1'b1, "R7");
        load_a(8'h30);
        drive(C_AND,  8'h24, 1'b0, 1'b1, "R7");
        load_a(8'h30);
        drive(C_AND,  8'h24, 1'b1, 1'b1, "R7");
        drive(C_OR,   8'h81, 1'b0, 1'b1, "R8");
        drive(C_XOR,  8'h81, 1'b0, 1'b1, "R3");
        // increment/decrement with carry set, then clear
        load_a(8'h00);
        drive(C_SUB,  8'hD1, 1'b0, 1'b1, "R5");
        drive(C_INC,  8'h00, 1'b0, 1'b1, "R9");
        drive(C_DEC,  8'h00, 1'b0, 1'b1, "R10");
        drive(C_DEC,  8'h00, 1'b0, 1'b1, "R10");
        load_a(8'h00);
        drive(C_DEC,  8'h00, 1'b0, 1'b1, "R10");
        drive(C_INC,  8'h00, 1'b0, 1'b1, "R9");
        // decimal adjust corners
        load_a(8'h15);
        drive(C_ADD,  8'h27, 1'b0, 1'b1, "R4");
        drive(C_DAJ,  8'h00, 1'b0, 1'b1, "R11");
        load_a(8'h88);
        drive(C_ADD,  8'h88, 1'b0, 1'b1, "R4");
        drive(C_DAJ,  8'h00, 1'b0, 1'b1, "R11");
        load_a(8'h9B);
        drive(C_DAJ,  8'h00, 1'b0, 1'b1, "R12");
        load_a(8'h50);
        drive(C_SUB,  8'h05, 1'b0, 1'b1, "R5");
        drive(C_DAJ,  8'h00, 1'b0, 1'b1, "R12");
        // no strobe, and unused codes
        drive(C_INC,  8'h00, 1'b0, 1'b0, "R2");
        drive(13,     8'h55, 1'b0, 1'b1, "R2");
        drive(15,     8'hAA, 1'b1, 1'b1, "R2");

        // pseudo-random operation stream
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            int op;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op = int'(lf[3:0]) % 11;
            drive(op, lf[15:8] ^ lf[7:0], lf[4], lf[5] | lf[6], req_of(op));
        end

        repeat (3) @(negedge clk);
        summary();
    end

endmodule